// File: doc/BRIEF.md
# Register-to-Register Operate Unit with Condition Flags

This block is the execute stage for the three register operate instructions of a small 16-bit load/store processor. It holds eight general registers and a three-flag condition set. When a valid instruction word arrives, it decodes add, bitwise AND and bitwise complement. It reads one or two source registers, or one register and a sign-extended 5-bit immediate. On the next clock edge it writes the result to the destination register and updates the flags.

A second write port lets a load path outside the block put a memory value into a register. That write updates the flags by the same rule. An observation port reads any register combinationally. Any other opcode is flagged as illegal and changes nothing.

Top module: `opunit_top`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0 and the flags read `cc_o` = 3'b010 (zero).
- R2: Opcode 4'b0001 in instr[15:12] adds. The destination is instr[11:9] and the first source is instr[8:6]. With instr[5]=0 the second source is the register in instr[2:0]. The sum wraps modulo 2^16.
- R3: With instr[5]=1, add and AND take instr[4:0] as a two's-complement value, sign-extended to 16 bits, as the second operand.
- R4: Opcode 4'b0101 writes the bitwise AND of its two operands to the destination.
- R5: Opcode 4'b1001 writes the bitwise complement of the register in instr[8:6] to the destination.
- R6: Every register write sets `cc_o` one-hot on the same edge: bit 2 when the value is negative, bit 1 when it is zero, bit 0 when it is positive.
- R7: A valid instruction with any other opcode drives `illegal_o` high in that cycle and leaves registers and flags unchanged.
- R8: While `instr_valid` is low, the instruction word has no effect and `illegal_o` stays low.
- R9: While `ld_we` is high, `ld_data` is written into register `ld_addr` on the clock edge and the flags follow R6.
- R10: When a legal instruction and a load write arrive in the same cycle, the instruction result is written and the load write is dropped.
- R11: `obs_data` shows the current contents of register `obs_addr` without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction word is present |
| instr | input | 16 | Instruction word |
| ld_we | input | 1 | Load-path write enable |
| ld_addr | input | 3 | Load-path destination register |
| ld_data | input | 16 | Load-path write value |
| obs_addr | input | 3 | Register to observe |
| obs_data | output | 16 | Contents of the observed register |
| cc_o | output | 3 | Flags: bit 2 negative, bit 1 zero, bit 0 positive |
| illegal_o | output | 1 | Valid instruction has an unsupported opcode |

## Verification
The bench adds 0x7FFF and 1, which must wrap to 0x8000 and set the negative flag. A design that saturates, or that sets the flag from a 17-bit sum, would show the positive flag instead. It applies negative immediates to both add and AND. A design that zero-extends the immediate would give a small positive operand and the wrong result.

It also sends an unsupported opcode and an instruction with the valid strobe low. A design that decodes loosely would corrupt a register or the flags. It presents a load write and an instruction in the same cycle. A design with the wrong priority would leave the load value in the register, or would write both.

// File: rtl/opunit_pkg.sv
// Package: shared types and constants of the operate unit.
// Assumes a 16-bit instruction word with the opcode in the top nibble.
package opunit_pkg;

    localparam int INSTR_W = 16;

    localparam logic [3:0] OPC_ADD = 4'b0001;
    localparam logic [3:0] OPC_AND = 4'b0101;
    localparam logic [3:0] OPC_NOT = 4'b1001;

    // Flag encodings: bit 2 negative, bit 1 zero, bit 0 positive
    localparam logic [2:0] CC_NEG  = 3'b100;
    localparam logic [2:0] CC_ZERO = 3'b010;
    localparam logic [2:0] CC_POS  = 3'b001;

    typedef enum logic [1:0] {
        K_NONE = 2'd0,
        K_ADD  = 2'd1,
        K_AND  = 2'd2,
        K_NOT  = 2'd3
    } op_kind_t;

endpackage

// File: rtl/opunit_decode.sv
// Module: splits an instruction word into operation kind, register
// fields and the sign-extended immediate operand.
// Assumes the caller ignores every field when wr_en is low.
module opunit_decode
    import opunit_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                 valid,
    input  logic [INSTR_W-1:0]   instr,
    output op_kind_t             kind,
    output logic [2:0]           dst,
    output logic [2:0]           src1,
    output logic [2:0]           src2,
    output logic                 use_imm,
    output logic [DATA_W-1:0]    imm,
    output logic                 wr_en,
    output logic                 illegal
);

    // Pick the operation kind from the opcode nibble
    always_comb begin
        unique case (instr[15:12])
            OPC_ADD: kind = K_ADD;
            OPC_AND: kind = K_AND;
            OPC_NOT: kind = K_NOT;
            default: kind = K_NONE;
        endcase
    end

    // Extract the register fields and sign-extend the immediate
    always_comb begin
        dst     = instr[11:9];
        src1    = instr[8:6];
        src2    = instr[2:0];
        use_imm = instr[5];
        imm     = {{(DATA_W-5){instr[4]}}, instr[4:0]};
    end

    // Qualify the write and the illegal strobe with valid
    always_comb begin
        wr_en   = valid && (kind != K_NONE);
        illegal = valid && (kind == K_NONE);
    end

endmodule

// File: rtl/opunit_alu.sv
// Module: computes the operate result from two operands.
// Assumes the add wraps and that no carry or overflow is kept.
module opunit_alu
    import opunit_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  op_kind_t             kind,
    input  logic [DATA_W-1:0]    opa,
    input  logic [DATA_W-1:0]    opb,
    output logic [DATA_W-1:0]    result
);

    // Select the arithmetic or logic function
    always_comb begin
        unique case (kind)
            K_ADD:   result = opa + opb;
            K_AND:   result = opa & opb;
            K_NOT:   result = ~opa;
            default: result = '0;
        endcase
    end

endmodule

// File: rtl/opunit_regfile.sv
// Module: the general register array, with two read ports, one
// observation port and one write port, plus the flag register that
// every write updates. Assumes a synchronous active-low reset.
module opunit_regfile
    import opunit_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int REG_CNT = 8,
    localparam int AW     = $clog2(REG_CNT)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [AW-1:0]        waddr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [AW-1:0]        ra1,
    input  logic [AW-1:0]        ra2,
    input  logic [AW-1:0]        rao,
    output logic [DATA_W-1:0]    rd1,
    output logic [DATA_W-1:0]    rd2,
    output logic [DATA_W-1:0]    rdo,
    output logic [2:0]           cc
);

    logic [DATA_W-1:0] regs [REG_CNT];
    logic [2:0]        cc_next;

    // One storage process per register
    for (genvar g = 0; g < REG_CNT; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (we && (waddr == AW'(g)))
                regs[g] <= wdata;
        end
    end

    // Classify the written value as negative, zero or positive
    always_comb begin
        if (wdata[DATA_W-1])
            cc_next = CC_NEG;
        else if (wdata == '0)
            cc_next = CC_ZERO;
        else
            cc_next = CC_POS;
    end

    // Update the flags on the edge of every register write
    always_ff @(posedge clk) begin
        if (!rst_n)
            cc <= CC_ZERO;
        else if (we)
            cc <= cc_next;
    end

    // Combinational read ports
    always_comb begin
        rd1 = regs[ra1];
        rd2 = regs[ra2];
        rdo = regs[rao];
    end

endmodule

// File: rtl/opunit_top.sv
// Module: top of the operate unit. It decodes the instruction, picks the
// second operand, runs the ALU and writes the register file. An operate
// result takes priority over the load-path write port.
// Assumes the instruction and load inputs are stable around the edge.
module opunit_top
    import opunit_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               instr_valid,
    input  logic [15:0]        instr,
    input  logic               ld_we,
    input  logic [2:0]         ld_addr,
    input  logic [DATA_W-1:0]  ld_data,
    input  logic [2:0]         obs_addr,
    output logic [DATA_W-1:0]  obs_data,
    output logic [2:0]         cc_o,
    output logic               illegal_o
);

    localparam int REG_CNT = 8;

    op_kind_t          kind;
    logic [2:0]        dst, src1, src2;
    logic              use_imm, op_we;
    logic [DATA_W-1:0] imm, rd1, rd2, opb, result;
    logic              rf_we;
    logic [2:0]        rf_waddr;
    logic [DATA_W-1:0] rf_wdata;

    opunit_decode #(.DATA_W(DATA_W)) dec_i (
        .valid   (instr_valid),
        .instr   (instr),
        .kind    (kind),
        .dst     (dst),
        .src1    (src1),
        .src2    (src2),
        .use_imm (use_imm),
        .imm     (imm),
        .wr_en   (op_we),
        .illegal (illegal_o)
    );

    // Second operand: register or sign-extended immediate
    always_comb opb = use_imm ? imm : rd2;

    opunit_alu #(.DATA_W(DATA_W)) alu_i (
        .kind   (kind),
        .opa    (rd1),
        .opb    (opb),
        .result (result)
    );

    // Write arbitration: the operate result wins over the load path
    always_comb begin
        rf_we    = op_we || ld_we;
        rf_waddr = op_we ? dst    : ld_addr;
        rf_wdata = op_we ? result : ld_data;
    end

    opunit_regfile #(.DATA_W(DATA_W), .REG_CNT(REG_CNT)) rf_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .waddr (rf_waddr),
        .wdata (rf_wdata),
        .ra1   (src1),
        .ra2   (src2),
        .rao   (obs_addr),
        .rd1   (rd1),
        .rd2   (rd2),
        .rdo   (obs_data),
        .cc    (cc_o)
    );

endmodule

// File: rtl/opunit_chk.sv
// Module: protocol checker for the operate unit, bound to the top.
// Assumes a synchronous active-low reset.
module opunit_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              instr_valid,
    input logic              ld_we,
    input logic [DATA_W-1:0] ld_data,
    input logic [2:0]        cc_o,
    input logic              illegal_o
);

    AST_RESET_FLAGS: assert property (@(posedge clk) !rst_n |=> cc_o == 3'b010); // R1

    AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cc_o) == 1); // R6

    AST_ILLEGAL_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal_o && !ld_we) |=> $stable(cc_o)); // R7

    AST_IDLE_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (!instr_valid && !ld_we) |=> $stable(cc_o)); // R8

    AST_NO_ILLEGAL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |-> !illegal_o); // R8

    AST_LOAD_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_we && !instr_valid) |=> (cc_o[1] == ($past(ld_data) == '0))); // R9

    AST_LOAD_NEG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_we && !instr_valid) |=> (cc_o[2] == $past(ld_data[DATA_W-1]))); // R9

endmodule

bind opunit_top opunit_chk #(.DATA_W(DATA_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .ld_we       (ld_we),
    .ld_data     (ld_data),
    .cc_o        (cc_o),
    .illegal_o   (illegal_o)
);

// File: tb/opunit_top_tb.sv
// Scoreboard bench: the driver task applies stimulus, updates a bench
// model and queues expected register and flag values; the monitor pops
// them and compares them through the observation port.
module opunit_top_tb_top;

    typedef struct {
        logic [2:0]  a;
        logic [15:0] d;
        logic [2:0]  cc;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr = '0;
    logic        ld_we = 1'b0;
    logic [2:0]  ld_addr = '0;
    logic [15:0] ld_data = '0;
    logic [2:0]  obs_addr = '0;
    logic [15:0] obs_data;
    logic [2:0]  cc_o;
    logic        illegal_o;

    int checks = 0;
    int fails  = 0;
    exp_t q[$];
    logic [15:0] m [8];
    logic [2:0]  mcc;

    always #10 clk = ~clk;  // 50 MHz

    opunit_top dut_i (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
        .obs_addr(obs_addr), .obs_data(obs_data), .cc_o(cc_o),
        .illegal_o(illegal_o)
    );

    function automatic logic [2:0] flags_of(logic [15:0] v);
        if (v[15]) return 3'b100;
        if (v == 16'h0) return 3'b010;
        return 3'b001;
    endfunction

    function automatic logic [15:0] rr(logic [3:0] op, int d, int s1, int s2);
        return {op, 3'(d), 3'(s1), 1'b0, 2'b00, 3'(s2)};
    endfunction

    function automatic logic [15:0] ri(logic [3:0] op, int d, int s1, logic [4:0] i5);
        return {op, 3'(d), 3'(s1), 1'b1, i5};
    endfunction

    function automatic logic [15:0] nt(int d, int s);
        return {4'b1001, 3'(d), 3'(s), 6'b111111};
    endfunction

    // Driver: one cycle of stimulus; the bench model computes expectations
    task automatic issue(input logic v, input logic [15:0] iw, input logic lw,
                         input logic [2:0] la, input logic [15:0] ldv,
                         input string tag);
        logic [3:0]  opc;
        logic        legal;
        logic [15:0] a, b, r;
        logic [2:0]  wa;
        opc   = iw[15:12];
        legal = (opc == 4'b0001) || (opc == 4'b0101) || (opc == 4'b1001);
        @(negedge clk);
        instr_valid = v; instr = iw; ld_we = lw; ld_addr = la; ld_data = ldv;
        #2;
        checks++;
        if (illegal_o !== (v && !legal)) begin
            fails++;
            $display("FAIL %s illegal_o: actual %b expected %b", tag, illegal_o, v && !legal);
        end
        @(posedge clk);
        #1;
        instr_valid = 1'b0; ld_we = 1'b0;
        wa = la;
        if (v && legal) begin
            a  = m[iw[8:6]];
            b  = iw[5] ? {{11{iw[4]}}, iw[4:0]} : m[iw[2:0]];
            r  = (opc == 4'b0001) ? a + b : (opc == 4'b0101) ? (a & b) : ~a;
            wa = iw[11:9];
            m[wa] = r; mcc = flags_of(r);
        end else if (lw) begin
            m[la] = ldv; mcc = flags_of(ldv);
        end
        if (v && !legal) wa = iw[11:9];
        if (!v && !lw) wa = iw[11:9];
        q.push_back('{a: wa, d: m[wa], cc: mcc, tag: tag});
        if (lw && (la != wa)) q.push_back('{a: la, d: m[la], cc: mcc, tag: tag});
    endtask

    // Monitor: pop expected items and compare through the observation port (R11)
    initial begin
        forever begin
            exp_t it;
            wait (q.size() != 0);
            it = q.pop_front();
            obs_addr = it.a;
            #1;
            checks++;
            if (obs_data !== it.d || cc_o !== it.cc) begin
                fails++;
                $display("FAIL %s R11 reg%0d: actual %h cc %b expected %h cc %b",
                         it.tag, it.a, obs_data, cc_o, it.d, it.cc);
            end
        end
    end

    // Watchdog
    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) m[i] = '0;
        mcc = 3'b010;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state of every register and the flags
        for (int i = 0; i < 8; i++) q.push_back('{a: 3'(i), d: 16'h0, cc: 3'b010, tag: "R1"});
        wait (q.size() == 0);
        // R9: load-path writes set flags
        issue(0, 0, 1, 1, 16'h1234, "R9 load pos");
        issue(0, 0, 1, 2, 16'hFFFE, "R9 load neg");
        issue(0, 0, 1, 3, 16'h7FFF, "R9 load max");
        // R2: register add
        issue(1, rr(4'b0001, 4, 1, 2), 0, 0, 0, "R2 add reg");
        // R3: negative immediate add
        issue(1, ri(4'b0001, 5, 1, 5'b11011), 0, 0, 0, "R3 add imm -5");
        // R2/R6: wrap to negative
        issue(1, ri(4'b0001, 6, 3, 5'b00001), 0, 0, 0, "R2 R6 wrap");
        // R4: register AND
        issue(1, rr(4'b0101, 7, 1, 2), 0, 0, 0, "R4 and reg");
        // R3/R4/R6: AND with zero gives zero flag
        issue(1, ri(4'b0101, 0, 1, 5'b00000), 0, 0, 0, "R4 R6 and zero");
        // R3: AND with sign-extended -16
        issue(1, ri(4'b0101, 1, 2, 5'b10000), 0, 0, 0, "R3 and imm -16");
        // R5: complement, source equals destination
        issue(1, nt(2, 2), 0, 0, 0, "R5 not");
        issue(1, nt(0, 0), 0, 0, 0, "R5 not zero");
        // R7: unsupported opcode changes nothing
        issue(1, {4'b0011, 3'd4, 9'h1FF}, 0, 0, 0, "R7 illegal");
        issue(1, {4'b1111, 3'd2, 9'h000}, 0, 0, 0, "R7 illegal2");
        // R8: valid low, no effect
        issue(0, ri(4'b0101, 4, 0, 5'b00000), 0, 0, 0, "R8 idle");
        // R10: instruction beats load write
        issue(1, ri(4'b0001, 3, 3, 5'b00001), 1, 3, 16'h5555, "R10 same reg");
        issue(1, ri(4'b0001, 4, 4, 5'b11111), 1, 0, 16'h9999, "R10 other reg");
        // R7 with concurrent load: load still applies
        issue(1, {4'b1101, 12'h000}, 1, 5, 16'h0000, "R7 R9 illegal plus load");
        // Final sweep of all registers (R11)
        for (int i = 0; i < 8; i++) q.push_back('{a: 3'(i), d: m[i], cc: mcc, tag: "R11 sweep"});
        wait (q.size() == 0);
        #5;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule